// File: doc/BRIEF.md
# Timer Compare/Capture Register Pair

This block holds a free-running up-counter and, for each channel pair, one primary general register and one auxiliary general register. The primary register of a pair has its own pin. The auxiliary register is set up by one 4-bit nibble of a shared control word. The nibble sets whether the auxiliary register compares or captures. It also selects which pin the register serves, either the primary pin of the pair or the auxiliary register's own pin, and what happens on a match or which edge starts a capture.

In compare mode a register drives its pin low, high or toggled one clock after the counter equals the register. In capture mode the register loads the counter when the selected edge appears on the synchronized pin input. When buffering is enabled for a pair, the auxiliary register stops acting by itself. It instead feeds the primary register on each primary compare match, or it takes the old primary value on each primary capture. A PWM-mode input cancels every effect of the control nibbles.

Top module: `tmr_pair_chan`

## Requirements
- R1: The counter `cnt_val` resets to 0. It increments by one on each clock while `run` is 1, wraps from all-ones to 0, and holds while `run` is 0.
- R2: The control word `ctl_val` resets to 0x88, which is 4'b1000 in every nibble. It loads `ctl_wdata` on the clock where `ctl_we` is 1. Pair p uses nibble bits [4p+3:4p]. Within the nibble, bits [1:0] are the action/edge code, bit 2 selects capture (1) or compare (0), and bit 3 selects the auxiliary register's own pin (1) or the primary pin of the pair (0).
- R3: For an auxiliary register in compare mode, a counter value equal to the register applies its code to the linked pin at the next clock edge. Code 00 leaves the pin alone, 01 drives it 0, 10 drives it 1 and 11 toggles it.
- R4: Pins and registers are numbered 0..NPAIR-1 for the primaries and NPAIR+p for the auxiliary register of pair p. The pin-select bit routes both compare actions and capture sources of the auxiliary register. A pin that is not selected is unaffected.
- R5: In capture mode, code 00 captures on a rising edge, 01 on a falling edge and 10 or 11 on both edges. The pin passes through two synchronizer flops. A pin change driven before clock edge 1 loads, at clock edge 3, the counter value held between edges 2 and 3.
- R6: Each primary register compares when its `pri_cap` bit is 0 and captures when it is 1. It uses its 2-bit `pri_act` field with the same codes on its own pin.
- R7: When a primary register and an auxiliary register linked to the primary pin both match in the same cycle, only the primary register's action is applied.
- R8: With `buf_en` set and both registers of the pair in compare mode, a primary compare match copies the auxiliary value into the primary register. Both registers of a buffered pair must be in the same mode.
- R9: With `buf_en` set and both registers in capture mode, a primary capture loads the counter into the primary register and moves the old primary value into the auxiliary register.
- R10: While `pwm_mode` is 1, an auxiliary register neither compares, captures nor buffers. Its value and its own pin hold.
- R11: All registers reset to 0. A write (`wr_en`, `wr_sel` = register number) loads `wr_data` at the next edge and takes precedence over a capture or buffer update in the same cycle.
- R12: While its pair is buffered, an auxiliary register makes no compare action and no capture of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Counter enable |
| pwm_mode | input | 1 | Cancels all control-nibble effects |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 4*NPAIR | Control word write data |
| ctl_val | output | 4*NPAIR | Current control word |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | clog2(2*NPAIR) | Register number to write |
| wr_data | input | CNT_W | Register write data |
| pri_cap | input | NPAIR | Primary mode per pair, 1 = capture |
| pri_act | input | 2*NPAIR | Primary action/edge code per pair |
| buf_en | input | NPAIR | Buffering enable per pair |
| pin_in | input | 2*NPAIR | Pin inputs for capture |
| pin_out | output | 2*NPAIR | Pin output registers |
| cnt_val | output | CNT_W | Counter value |
| gr_val | output | 2*NPAIR*CNT_W | All register values, register i at bits [i*CNT_W +: CNT_W] |

## Verification
The bench builds the block with CNT_W = 8 and NPAIR = 2. The 8-bit counter wraps every 256 cycles, so wrap-around, matches placed just past the current count and many random compare and capture rounds all fit in a short run. Two pairs make it possible to check that one pair's nibble leaves the other pair's pins and registers alone. They also allow the PWM-mode cancellation to be exercised on the second pair while the first stays configured.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

   typedef enum logic [1:0] {
      ACT_NONE   = 2'b00,
      ACT_LOW    = 2'b01,
      ACT_HIGH   = 2'b10,
      ACT_TOGGLE = 2'b11
   } act_e;

   // Auxiliary nibble, MSB first: pin select, function select, action/edge code
   typedef struct packed {
      logic own_pin;
      logic capture;
      act_e act;
   } aux_cfg_t;

   function automatic logic apply_act(logic cur, act_e a);
      case (a)
         ACT_LOW:    return 1'b0;
         ACT_HIGH:   return 1'b1;
         ACT_TOGGLE: return ~cur;
         default:    return cur;
      endcase
   endfunction

   function automatic logic edge_hit(logic [1:0] code, logic rise, logic fall);
      case (code)
         2'b00:   return rise;
         2'b01:   return fall;
         default: return rise | fall;
      endcase
   endfunction

endpackage

// File: rtl/tpc_counter.sv
module tpc_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   output logic [CNT_W-1:0] cnt
);

   if (CNT_W < 2) begin : g_bad_width
      $error("tpc_counter: CNT_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (run) cnt <= cnt + CNT_W'(1);
   end

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> cnt == CNT_W'($past(cnt) + CNT_W'(1))); // R1
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(cnt)); // R1

endmodule

// File: rtl/tpc_edge.sv
module tpc_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tpc_edge: SYNC_STAGES must be at least 2");
   end

   // SYNC_STAGES synchronizer flops plus one history flop
   logic [SYNC_STAGES:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[SYNC_STAGES-1:0], pin};
   end

   assign rise =  sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
   assign fall = ~sh_q[SYNC_STAGES-1] &  sh_q[SYNC_STAGES];

endmodule

// File: rtl/tpc_pair.sv
module tpc_pair
   import tpc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  aux_cfg_t         cfg,
   input  logic             pri_cap,
   input  logic [1:0]       pri_act,
   input  logic             buf_en,
   input  logic             pwm,
   input  logic             wr_pri,
   input  logic             wr_aux,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             pin_pri_in,
   input  logic             pin_aux_in,
   output logic [CNT_W-1:0] pri_val,
   output logic [CNT_W-1:0] aux_val,
   output logic             pin_pri,
   output logic             pin_aux
);

   logic pr_rise, pr_fall, ax_rise, ax_fall;
   logic src_rise, src_fall;
   logic aux_on, buffered;
   logic pri_match, pri_capt, aux_match, aux_capt;
   logic [CNT_W-1:0] pri_d, aux_d;
   logic pin_pri_d, pin_aux_d;

   tpc_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge_pri (
      .clk(clk), .rst_n(rst_n), .pin(pin_pri_in), .rise(pr_rise), .fall(pr_fall));
   tpc_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge_aux (
      .clk(clk), .rst_n(rst_n), .pin(pin_aux_in), .rise(ax_rise), .fall(ax_fall));

   assign src_rise  = cfg.own_pin ? ax_rise : pr_rise;
   assign src_fall  = cfg.own_pin ? ax_fall : pr_fall;
   assign aux_on    = !pwm;
   assign buffered  = aux_on && buf_en;

   assign pri_match = !pri_cap && (cnt == pri_val);
   assign pri_capt  =  pri_cap && edge_hit(pri_act, pr_rise, pr_fall);
   assign aux_match = aux_on && !buf_en && !cfg.capture && (cnt == aux_val);
   assign aux_capt  = aux_on && !buf_en &&  cfg.capture &&
                      edge_hit(cfg.act, src_rise, src_fall);

   always_comb begin
      pri_d = pri_val;
      if (wr_pri)                     pri_d = wr_data;
      else if (pri_capt)              pri_d = cnt;
      else if (buffered && pri_match) pri_d = aux_val;

      aux_d = aux_val;
      if (wr_aux)                    aux_d = wr_data;
      else if (aux_capt)             aux_d = cnt;
      else if (buffered && pri_capt) aux_d = pri_val;

      pin_pri_d = pin_pri;
      if (pri_match)                        pin_pri_d = apply_act(pin_pri, act_e'(pri_act));
      else if (aux_match && !cfg.own_pin)   pin_pri_d = apply_act(pin_pri, cfg.act);

      pin_aux_d = pin_aux;
      if (aux_match && cfg.own_pin)         pin_aux_d = apply_act(pin_aux, cfg.act);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pri_val <= '0;
         aux_val <= '0;
         pin_pri <= 1'b0;
         pin_aux <= 1'b0;
      end else begin
         pri_val <= pri_d;
         aux_val <= aux_d;
         pin_pri <= pin_pri_d;
         pin_aux <= pin_aux_d;
      end
   end

   AST_CMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      aux_match && cfg.own_pin && cfg.act == ACT_HIGH |=> pin_aux); // R3
   AST_PRI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      pri_match && pri_act == 2'b01 |=> !pin_pri); // R7
   AST_CAP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      aux_capt && !wr_aux |=> aux_val == $past(cnt)); // R5
   AST_BUF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      buffered && pri_match && !wr_pri |=> pri_val == $past(aux_val)); // R8
   AST_BUF_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      buffered && pri_capt && !wr_aux |=> aux_val == $past(pri_val)); // R9
   AST_BUF_SAME_FUNC: assert property (@(posedge clk) disable iff (!rst_n)
      buffered |-> pri_cap == cfg.capture); // R8
   AST_PWM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      pwm && !wr_aux |=> $stable(aux_val) && $stable(pin_aux)); // R10
   AST_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_aux |=> aux_val == $past(wr_data)); // R11

endmodule

// File: rtl/tmr_pair_chan.sv
module tmr_pair_chan
   import tpc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int NPAIR       = 2,
   parameter int SYNC_STAGES = 2,
   localparam int NREG       = 2 * NPAIR,
   localparam int CTL_W      = 4 * NPAIR,
   localparam int SEL_W      = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  run,
   input  logic                  pwm_mode,
   input  logic                  ctl_we,
   input  logic [CTL_W-1:0]      ctl_wdata,
   output logic [CTL_W-1:0]      ctl_val,
   input  logic                  wr_en,
   input  logic [SEL_W-1:0]      wr_sel,
   input  logic [CNT_W-1:0]      wr_data,
   input  logic [NPAIR-1:0]      pri_cap,
   input  logic [2*NPAIR-1:0]    pri_act,
   input  logic [NPAIR-1:0]      buf_en,
   input  logic [NREG-1:0]       pin_in,
   output logic [NREG-1:0]       pin_out,
   output logic [CNT_W-1:0]      cnt_val,
   output logic [NREG*CNT_W-1:0] gr_val
);

   localparam logic [CTL_W-1:0] CTL_RST = {NPAIR{4'b1000}};

   if (NPAIR < 1) begin : g_bad_pairs
      $error("tmr_pair_chan: NPAIR must be at least 1");
   end

   logic [CTL_W-1:0] ctl_q;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_q <= CTL_RST;
      else if (ctl_we) ctl_q <= ctl_wdata;
   end

   assign ctl_val = ctl_q;
   assign cnt_val = cnt;

   tpc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt));

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      logic [CNT_W-1:0] pri_v, aux_v;
      logic wr_p, wr_a;

      assign wr_p = wr_en && (wr_sel == SEL_W'(p));
      assign wr_a = wr_en && (wr_sel == SEL_W'(NPAIR + p));

      tpc_pair #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_pair (
         .clk        (clk),
         .rst_n      (rst_n),
         .cnt        (cnt),
         .cfg        (aux_cfg_t'(ctl_q[4*p +: 4])),
         .pri_cap    (pri_cap[p]),
         .pri_act    (pri_act[2*p +: 2]),
         .buf_en     (buf_en[p]),
         .pwm        (pwm_mode),
         .wr_pri     (wr_p),
         .wr_aux     (wr_a),
         .wr_data    (wr_data),
         .pin_pri_in (pin_in[p]),
         .pin_aux_in (pin_in[NPAIR + p]),
         .pri_val    (pri_v),
         .aux_val    (aux_v),
         .pin_pri    (pin_out[p]),
         .pin_aux    (pin_out[NPAIR + p])
      );

      assign gr_val[p*CNT_W +: CNT_W]           = pri_v;
      assign gr_val[(NPAIR+p)*CNT_W +: CNT_W]   = aux_v;
   end

   AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |=> ctl_q == $past(ctl_wdata)); // R2
   AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_we |=> $stable(ctl_q)); // R2

endmodule

// File: tb/tmr_pair_chan_bench.sv
module tmr_pair_chan_bench;

   localparam int W = 8;
   localparam int NP = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic run = 1'b0;
   logic pwm_mode = 1'b0;
   logic ctl_we = 1'b0;
   logic [7:0] ctl_wdata = '0;
   logic [7:0] ctl_val;
   logic wr_en = 1'b0;
   logic [1:0] wr_sel = '0;
   logic [W-1:0] wr_data = '0;
   logic [1:0] pri_cap = '0;
   logic [3:0] pri_act = '0;
   logic [1:0] buf_en = '0;
   logic [3:0] pin_in = '0;
   logic [3:0] pin_out;
   logic [W-1:0] cnt_val;
   logic [4*W-1:0] gr_val;

   int checks = 0;
   int errors = 0;
   logic [3:0] exp_pin = '0;
   int unsigned seed = 32'd20240611;

   always #4 clk = ~clk;

   tmr_pair_chan #(.CNT_W(W), .NPAIR(NP)) u_tmr_pair_chan (
      .clk(clk), .rst_n(rst_n), .run(run), .pwm_mode(pwm_mode),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_val(ctl_val),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .pri_cap(pri_cap), .pri_act(pri_act), .buf_en(buf_en),
      .pin_in(pin_in), .pin_out(pin_out), .cnt_val(cnt_val), .gr_val(gr_val));

   function automatic logic act_f(logic cur, logic [1:0] a);
      case (a)
         2'b01:   return 1'b0;
         2'b10:   return 1'b1;
         2'b11:   return ~cur;
         default: return cur;
      endcase
   endfunction

   function automatic logic [W-1:0] gr(int idx);
      return gr_val[idx*W +: W];
   endfunction

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_ctl(logic [7:0] v);
      ctl_we = 1'b1; ctl_wdata = v;
      @(negedge clk);
      ctl_we = 1'b0;
   endtask

   task automatic wr_reg(int sel, logic [W-1:0] d);
      wr_en = 1'b1; wr_sel = 2'(sel); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_val(logic [W-1:0] v);
      while (cnt_val != v) @(negedge clk);
   endtask

   // R3 / R4: one compare action on an auxiliary register
   task automatic cmp_test(int pair, bit own, logic [1:0] act, int off, string tag);
      logic [7:0] cv;
      logic [W-1:0] v;
      int idx;
      wr_ctl(8'h88);
      v = W'(int'(cnt_val) + off);
      wr_reg(pair, v ^ 8'h80);
      wr_reg(NP + pair, v);
      cv = 8'h88;
      cv[pair*4 +: 4] = {own, 1'b0, act};
      wr_ctl(cv);
      wait_val(v);
      step(1);
      idx = own ? NP + pair : pair;
      exp_pin[idx] = act_f(exp_pin[idx], act);
      chk(tag, int'(pin_out), int'(exp_pin));
   endtask

   // R5: drive one pin level and check the capture result three edges later
   task automatic cap_step(int pidx, logic val, int ridx, bit hit, string tag);
      logic [W-1:0] prev, c0;
      prev = gr(ridx);
      c0 = cnt_val;
      pin_in[pidx] = val;
      step(3);
      chk(tag, int'(gr(ridx)), hit ? int'(W'(c0 + 2)) : int'(prev));
      step(2);
   endtask

   initial begin : wdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [W-1:0] v, c, x;
      step(2);
      rst_n = 1'b1;
      step(1);
      // reset state
      chk("R1 counter reset", int'(cnt_val), 0);
      chk("R2 control reset", int'(ctl_val), 8'h88);
      chk("R3 pins reset", int'(pin_out), 0);
      chk("R11 registers reset", int'(gr_val), 0);

      // R1 counting, holding and wrap
      step(3);
      chk("R1 hold while stopped", int'(cnt_val), 0);
      run = 1'b1;
      step(5);
      chk("R1 counting", int'(cnt_val), 5);
      run = 1'b0;
      step(4);
      chk("R1 hold after stop", int'(cnt_val), 5);
      run = 1'b1;
      wait_val(8'hFF);
      step(1);
      chk("R1 wrap", int'(cnt_val), 0);

      // R2 control load and R11 plain writes
      wr_ctl(8'h5A);
      chk("R2 control load", int'(ctl_val), 8'h5A);
      wr_ctl(8'h88);
      wr_reg(3, 8'hC3);
      chk("R11 write D", int'(gr(3)), 8'hC3);

      // R3 each action code on own pin, R4 primary-pin routing
      cmp_test(0, 1'b1, 2'b10, 8, "R3 high on own pin");
      cmp_test(0, 1'b1, 2'b01, 8, "R3 low on own pin");
      cmp_test(0, 1'b1, 2'b11, 8, "R3 toggle on own pin");
      cmp_test(0, 1'b1, 2'b00, 8, "R3 disabled action");
      cmp_test(1, 1'b0, 2'b11, 9, "R4 routed to primary pin");

      // R6 primary compare
      wr_ctl(8'h88);
      pri_act = 4'b0010;
      v = W'(cnt_val + 4);
      wr_reg(0, v);
      wait_val(v); step(1);
      exp_pin[0] = 1'b1;
      chk("R6 primary compare high", int'(pin_out), int'(exp_pin));

      // R7 primary wins the shared pin: primary high vs auxiliary toggle
      v = W'(cnt_val + 6);
      wr_reg(0, v);
      wr_reg(2, v);
      wr_ctl(8'h83);
      wait_val(v); step(1);
      chk("R7 primary wins", int'(pin_out), int'(exp_pin));
      pri_act = 4'b0000;

      // R5 capture edges on own pin C
      wr_ctl(8'h8C);
      step(4);
      cap_step(2, 1'b1, 2, 1'b1, "R5 rising captured");
      cap_step(2, 1'b0, 2, 1'b0, "R5 falling ignored in rising mode");
      wr_ctl(8'h8D);
      cap_step(2, 1'b1, 2, 1'b0, "R5 rising ignored in falling mode");
      cap_step(2, 1'b0, 2, 1'b1, "R5 falling captured");
      wr_ctl(8'h8F);
      cap_step(2, 1'b1, 2, 1'b1, "R5 both edges rise");
      cap_step(2, 1'b0, 2, 1'b1, "R5 both edges fall");
      wr_ctl(8'h84);
      cap_step(2, 1'b1, 2, 1'b0, "R4 capture ignores own pin when primary selected");
      cap_step(0, 1'b1, 2, 1'b1, "R4 capture from primary pin");

      // R8 / R12 buffered compare
      wr_ctl(8'h8B);
      pin_in = '0;
      step(4);
      buf_en[0] = 1'b1;
      c = cnt_val;
      wr_reg(2, W'(c + 5));
      wr_reg(0, W'(c + 9));
      wait_val(W'(c + 9)); step(1);
      chk("R8 buffer transfer", int'(gr(0)), int'(W'(c + 5)));
      chk("R12 buffered register no toggle", int'(pin_out), int'(exp_pin));
      buf_en[0] = 1'b0;

      // R9 / R12 buffered capture
      wr_ctl(8'h8C);
      pri_cap[0] = 1'b1;
      buf_en[0] = 1'b1;
      wr_reg(0, 8'h11);
      cap_step(2, 1'b1, 2, 1'b0, "R12 buffered register no capture");
      x = cnt_val;
      pin_in[0] = 1'b1;
      step(3);
      chk("R9 primary captured", int'(gr(0)), int'(W'(x + 2)));
      chk("R9 old primary moved", int'(gr(2)), 8'h11);
      buf_en[0] = 1'b0;
      pri_cap[0] = 1'b0;
      pin_in = '0;
      step(4);

      // R10 PWM mode cancels the nibble
      pwm_mode = 1'b1;
      wr_ctl(8'hB8);
      v = W'(cnt_val + 4);
      wr_reg(3, v);
      wait_val(v); step(2);
      chk("R10 no compare action in PWM mode", int'(pin_out), int'(exp_pin));
      wr_ctl(8'hE8);
      cap_step(3, 1'b1, 3, 1'b0, "R10 no capture in PWM mode");
      pin_in[3] = 1'b0;
      step(4);
      pwm_mode = 1'b0;

      // R11 write beats buffer transfer in the same cycle
      wr_ctl(8'h88);
      buf_en[0] = 1'b1;
      wr_reg(2, 8'h55);
      v = W'(cnt_val + 5);
      wr_reg(0, v);
      wait_val(v);
      wr_reg(0, 8'h99);
      chk("R11 write precedence", int'(gr(0)), 8'h99);
      buf_en[0] = 1'b0;

      // random compare rounds (R3, R4)
      for (int i = 0; i < 40; i++) begin
         int pr, off;
         bit own;
         logic [1:0] a;
         pr  = int'($urandom(seed) % 2);
         seed = seed + 1;
         own = 1'($urandom() % 2);
         a   = 2'($urandom() % 4);
         off = 6 + int'($urandom() % 25);
         cmp_test(pr, own, a, off, own ? "R3 random own pin" : "R4 random primary pin");
      end

      // random capture rounds (R5, R4)
      wr_ctl(8'h88);
      pin_in = '0;
      step(4);
      for (int i = 0; i < 30; i++) begin
         int pr, pidx;
         bit own, rise, hit;
         logic [1:0] code;
         logic [7:0] cv;
         pr   = int'($urandom() % 2);
         own  = 1'($urandom() % 2);
         code = 2'($urandom() % 4);
         cv = 8'h88;
         cv[pr*4 +: 4] = {own, 1'b1, code};
         wr_ctl(cv);
         step(4);
         pidx = own ? NP + pr : pr;
         rise = !pin_in[pidx];
         hit = (code == 2'b00) ? rise : (code == 2'b01) ? !rise : 1'b1;
         cap_step(pidx, rise, NP + pr, hit, "R5 random capture");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule